// File: doc/BRIEF.md
# Prioritized Two-Bank Interrupt Controller

This block collects 64 interrupt request lines, split into two banks of 32, and turns them into two processor-facing outputs: an urgent line for the two most urgent priority values and a normal line for the rest. A rising edge on a request line latches a pending bit. Each source has an enable bit and a 3-bit priority. A pending source only takes part in signalling when it is enabled. Software services a request by writing a one to its pending bit.

Alongside the two outputs, the block names the most urgent enabled pending source. It gives both the source number and an entry address, formed from a software-written base plus four times that number. All state is reached through a plain 32-bit register port. Writes take effect on the clock edge. Read data is combinational from the address.

Register map (word offsets in bytes):
- 0x00 and 0x04: urgent-class pending view of bank 0 and bank 1.
- 0x08 and 0x0C: normal-class pending view of bank 0 and bank 1.
- 0x18 and 0x1C: enables for bank 0 and bank 1.
- 0x20: view control.
- 0x24: entry base.
- 0x30 to 0x4C: eight priority words.

Top module: `prio_intc`

## Requirements
- R1: After reset all pending bits, all enable bits, the view-control bit and the entry base read as zero, every source priority reads as 7, and `fiq_o`, `irq_o` and `act_valid_o` are low.
- R2: A rising edge on `req_i[n]` (low in one cycle, high the next) sets the pending bit of source n, which is bit n mod 32 of bank n/32. A line that simply stays high sets nothing further after its bit is cleared.
- R3: Offsets 0x00/0x04 show the pending bits of sources whose priority is 0 or 1. Offsets 0x08/0x0C show the pending bits of sources whose priority is 2 to 7. With view-control bit 0 at 0, disabled sources are shown too. With it at 1, only enabled sources are shown.
- R4: Writing a 1 to bit k of any pending offset of a bank clears the pending bit of that bank's source k, whatever its class. Zero bits in the write change nothing, and writing all ones clears the whole bank.
- R5: A request edge arriving in the same cycle as a clear write for that bit leaves the bit pending.
- R6: Offsets 0x18/0x1C hold the enable bits (1 = enabled). A disabled pending source drives neither output and is never reported as active.
- R7: The priority word at offset 0x30+4k holds source 8k+j in bits [4j+2:4j]. Bit 4j+3 reads as 0 and ignores writes.
- R8: `fiq_o` is high exactly when some enabled pending source has priority 0 or 1. `irq_o` is high exactly when some enabled pending source has priority 2 to 7. Both follow the registered state with no extra delay, so they drop in the cycle after the clearing write.
- R9: `act_valid_o` is high when any enabled source is pending. `act_id_o` is then the one with the numerically smallest priority, with ties going to the lowest source number.
- R10: `act_addr_o` equals the entry base (offset 0x24, all 32 bits writable) plus 4 times `act_id_o`. The view-control word at 0x20 keeps only bit 0, and its other bits read as 0.
- R11: Reads from unmapped word offsets return 0 and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 64 | Request lines, edge latched |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| fiq_o | output | 1 | Urgent-class interrupt |
| irq_o | output | 1 | Normal-class interrupt |
| act_valid_o | output | 1 | An enabled source is pending |
| act_id_o | output | 6 | Most urgent enabled pending source |
| act_addr_o | output | 32 | Entry address of that source |

## Verification
The hardest situation to reach from the ports is a request edge and a clear write for the same bit landing on one clock edge. The bench gets there by raising the request line and presenting the clearing write on the same falling edge, so both reach the next rising edge together. The bench then holds the line high through a second clear, which shows that a level does not re-pend. Priority ties across banks are built by giving a bank-1 source and a bank-0 source the same value and then lowering the bank-1 one.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W   = 32;
  localparam int BANK_W   = DATA_W;
  localparam int NIB_W    = 4;
  localparam int PRIO_PER_WORD = DATA_W / NIB_W;
  // word indices (byte offset / 4); software depends on these
  localparam int WI_FPEND0 = 0;
  localparam int WI_NPEND0 = 2;
  localparam int WI_EN0    = 6;
  localparam int WI_CTRL   = 8;
  localparam int WI_BASE   = 9;
  localparam int WI_PRIO0  = 12;
endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] edge_o,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] pend_q;

  assign edge_o = req_i & ~prev_q;
  assign pend_o = pend_q;

  // prev resets high so a line held high through reset raises nothing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      pend_q <= '0;
    end else begin
      prev_q <= req_i;
      pend_q <= (pend_q & ~clr_i) | edge_o;
    end
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NSRC     = 64,
  parameter int PRIO_W   = 3,
  parameter int FAST_MAX = 1,
  parameter int ADDR_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_we,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic [NSRC-1:0]              pend_i,
  output logic [NSRC-1:0]              en_o,
  output logic [NSRC-1:0][PRIO_W-1:0]  prio_o,
  output logic [NSRC-1:0]              fast_o,
  output logic [NSRC-1:0]              clr_o,
  output logic [DATA_W-1:0]            base_o
);
  localparam int NBANK  = NSRC / BANK_W;
  localparam int NPREG  = NSRC / PRIO_PER_WORD;
  localparam int WIDX_W = ADDR_W - 2;

  logic [NSRC-1:0]             en_q;
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic                        view_en_q;
  logic [DATA_W-1:0]           base_q;
  logic [WIDX_W-1:0]           widx;
  logic                        aligned;
  logic [NSRC-1:0]             view;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign en_o    = en_q;
  assign prio_o  = prio_q;
  assign base_o  = base_q;
  assign view    = view_en_q ? (pend_i & en_q) : pend_i;

  for (genvar s = 0; s < NSRC; s++) begin : g_class
    assign fast_o[s] = (prio_q[s] <= PRIO_W'(FAST_MAX));
  end

  // clear strobes from either pending view of a bank
  always_comb begin
    clr_o = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bus_we && aligned &&
          (widx == WIDX_W'(WI_FPEND0 + b) || widx == WIDX_W'(WI_NPEND0 + b)))
        clr_o[b*BANK_W +: BANK_W] = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      prio_q    <= '1;
      view_en_q <= 1'b0;
      base_q    <= '0;
    end else if (bus_we && aligned) begin
      for (int b = 0; b < NBANK; b++)
        if (widx == WIDX_W'(WI_EN0 + b))
          en_q[b*BANK_W +: BANK_W] <= bus_wdata;
      for (int k = 0; k < NPREG; k++)
        if (widx == WIDX_W'(WI_PRIO0 + k))
          for (int j = 0; j < PRIO_PER_WORD; j++)
            prio_q[k*PRIO_PER_WORD + j] <= bus_wdata[NIB_W*j +: PRIO_W];
      if (widx == WIDX_W'(WI_CTRL))
        view_en_q <= bus_wdata[0];
      if (widx == WIDX_W'(WI_BASE))
        base_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int b = 0; b < NBANK; b++) begin
        if (widx == WIDX_W'(WI_FPEND0 + b))
          bus_rdata = view[b*BANK_W +: BANK_W] & fast_o[b*BANK_W +: BANK_W];
        if (widx == WIDX_W'(WI_NPEND0 + b))
          bus_rdata = view[b*BANK_W +: BANK_W] & ~fast_o[b*BANK_W +: BANK_W];
        if (widx == WIDX_W'(WI_EN0 + b))
          bus_rdata = en_q[b*BANK_W +: BANK_W];
      end
      for (int k = 0; k < NPREG; k++)
        if (widx == WIDX_W'(WI_PRIO0 + k))
          for (int j = 0; j < PRIO_PER_WORD; j++)
            bus_rdata[NIB_W*j +: PRIO_W] = prio_q[k*PRIO_PER_WORD + j];
      if (widx == WIDX_W'(WI_CTRL))
        bus_rdata = {{(DATA_W-1){1'b0}}, view_en_q};
      if (widx == WIDX_W'(WI_BASE))
        bus_rdata = base_q;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NSRC   = 64,
  parameter int PRIO_W = 3
) (
  input  logic [NSRC-1:0]             live_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  output logic                        valid_o,
  output logic [$clog2(NSRC)-1:0]     id_o
);
  localparam int NLVL = 1 << PRIO_W;
  localparam int IDW  = $clog2(NSRC);

  logic [NLVL-1:0][NSRC-1:0] lvl_mask;
  logic [NSRC-1:0]           sel_mask;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign lvl_mask[l][s] = live_i[s] && (prio_i[s] == PRIO_W'(l));
    end
  end

  // most urgent non-empty level first, then lowest index in it
  always_comb begin
    logic found;
    found    = 1'b0;
    sel_mask = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (!found && (|lvl_mask[l])) begin
        sel_mask = lvl_mask[l];
        found    = 1'b1;
      end
    end
    id_o = '0;
    for (int s = NSRC - 1; s >= 0; s--)
      if (sel_mask[s]) id_o = IDW'(s);
  end

  assign valid_o = |live_i;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NSRC     = 64,
  parameter int PRIO_W   = 3,
  parameter int FAST_MAX = 1,
  parameter int ADDR_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         req_i,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    fiq_o,
  output logic                    irq_o,
  output logic                    act_valid_o,
  output logic [$clog2(NSRC)-1:0] act_id_o,
  output logic [DATA_W-1:0]       act_addr_o
);
  logic [NSRC-1:0]             pend_w;
  logic [NSRC-1:0]             edge_w;
  logic [NSRC-1:0]             clr_w;
  logic [NSRC-1:0]             en_w;
  logic [NSRC-1:0]             fast_w;
  logic [NSRC-1:0][PRIO_W-1:0] prio_w;
  logic [DATA_W-1:0]           base_w;
  logic [NSRC-1:0]             live_w;

  intc_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_w),
    .edge_o(edge_w), .pend_o(pend_w)
  );

  intc_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .FAST_MAX(FAST_MAX), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_i(pend_w),
    .en_o(en_w), .prio_o(prio_w), .fast_o(fast_w), .clr_o(clr_w), .base_o(base_w)
  );

  assign live_w = pend_w & en_w;

  intc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .live_i(live_w), .prio_i(prio_w), .valid_o(act_valid_o), .id_o(act_id_o)
  );

  assign fiq_o      = |(live_w & fast_w);
  assign irq_o      = |(live_w & ~fast_w);
  assign act_addr_o = base_w + (DATA_W'(act_id_o) << 2);
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NSRC     = 64,
  parameter int PRIO_W   = 3,
  parameter int FAST_MAX = 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        fiq_o,
  input logic                        irq_o,
  input logic                        act_valid_o,
  input logic [$clog2(NSRC)-1:0]     act_id_o,
  input logic [NSRC-1:0]             pend_w,
  input logic [NSRC-1:0]             edge_w,
  input logic [NSRC-1:0]             clr_w,
  input logic [NSRC-1:0]             en_w,
  input logic [NSRC-1:0][PRIO_W-1:0] prio_w
);
  // R5: a new edge wins over a simultaneous clear
  a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_w & clr_w) != '0) |=> ((pend_w & $past(edge_w & clr_w)) == $past(edge_w & clr_w)));

  // R4: a clear with no edge removes the bit
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_w & ~edge_w) != '0) |=> ((pend_w & $past(clr_w & ~edge_w)) == '0));

  // R9: the reported source is enabled and pending
  a_r9_active_live: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_o |-> (en_w[act_id_o] && pend_w[act_id_o]));

  // R8: urgent line means the winner is of urgent class
  a_r8_fast_winner: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (act_valid_o && (prio_w[act_id_o] <= PRIO_W'(FAST_MAX))));

  // R8: normal line alone means the winner is of normal class
  a_r8_normal_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !fiq_o) |-> (act_valid_o && (prio_w[act_id_o] > PRIO_W'(FAST_MAX))));

  // R6: nothing live, nothing signalled
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid_o |-> (!fiq_o && !irq_o));
endmodule

bind prio_intc intc_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W), .FAST_MAX(FAST_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .fiq_o(fiq_o), .irq_o(irq_o),
  .act_valid_o(act_valid_o), .act_id_o(act_id_o), .pend_w(pend_w),
  .edge_w(edge_w), .clr_w(clr_w), .en_w(en_w), .prio_w(prio_w)
);

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq, irq, act_valid;
  logic [5:0]  act_id;
  logic [31:0] act_addr;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  prio_intc dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .fiq_o(fiq), .irq_o(irq),
    .act_valid_o(act_valid), .act_id_o(act_id), .act_addr_o(act_addr)
  );

  // {write, addr, data, expected read}
  localparam int NT = 18;
  localparam logic [72:0] TBL [NT] = '{
    {1'b1, 8'h18, 32'hA5A50F0F, 32'h0}, {1'b0, 8'h18, 32'h0, 32'hA5A50F0F},  // R6
    {1'b1, 8'h1C, 32'h00000001, 32'h0}, {1'b0, 8'h1C, 32'h0, 32'h00000001},  // R6
    {1'b1, 8'h30, 32'hFFFFFFFF, 32'h0}, {1'b0, 8'h30, 32'h0, 32'h77777777},  // R7
    {1'b1, 8'h30, 32'h01234567, 32'h0}, {1'b0, 8'h30, 32'h0, 32'h01234567},  // R7
    {1'b1, 8'h4C, 32'h76543210, 32'h0}, {1'b0, 8'h4C, 32'h0, 32'h76543210},  // R7
    {1'b1, 8'h20, 32'hFFFFFFFF, 32'h0}, {1'b0, 8'h20, 32'h0, 32'h00000001},  // R10
    {1'b1, 8'h20, 32'h00000000, 32'h0}, {1'b0, 8'h20, 32'h0, 32'h00000000},  // R10
    {1'b1, 8'h24, 32'h80001000, 32'h0}, {1'b0, 8'h24, 32'h0, 32'h80001000},  // R10
    {1'b1, 8'h10, 32'hFFFFFFFF, 32'h0}, {1'b0, 8'h10, 32'h0, 32'h00000000}   // R11
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1;
    check(rdata, exp, tag);
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    req[n] = 1'b1;
    @(negedge clk);
    req[n] = 1'b0;
  endtask

  task automatic outs(input logic f, input logic i, input logic v, input string tag);
    #1;
    check({29'b0, f, i, v}, {29'b0, fiq, irq, act_valid}, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    check({29'b0, fiq, irq, act_valid}, 32'h0, "R1 outputs");
    rd(8'h00, 32'h0, "R1 pending");
    rd(8'h18, 32'h0, "R1 enable");
    rd(8'h30, 32'h77777777, "R1 priority");
    rd(8'h20, 32'h0, "R1 control");
    rd(8'h24, 32'h0, "R1 base");

    for (int t = 0; t < NT; t++) begin
      if (TBL[t][72]) wr(TBL[t][71:64], TBL[t][63:32]);
      else            rd(TBL[t][71:64], TBL[t][31:0], "R6 R7 R10 R11 table");
    end

    // clean setup
    wr(8'h18, 32'h0); wr(8'h1C, 32'h0);
    wr(8'h30, 32'h77777777); wr(8'h4C, 32'h77777777);
    wr(8'h24, 32'h00000100);

    // R2 R3: disabled normal source 5 latches and shows in normal view
    pulse(5);
    rd(8'h08, 32'h00000020, "R2 normal view src5");
    rd(8'h00, 32'h0, "R3 urgent view empty");
    outs(1'b0, 1'b0, 1'b0, "R6 disabled source silent");

    // R8 R9 R10: enable source 5
    wr(8'h18, 32'h00000020);
    outs(1'b0, 1'b1, 1'b1, "R8 normal line");
    check({26'b0, act_id}, 32'd5, "R9 id src5");
    check(act_addr, 32'h114, "R10 addr src5");

    // R3 masked view: source 40 pending but disabled
    wr(8'h20, 32'h1);
    pulse(40);
    rd(8'h0C, 32'h0, "R3 masked view hides disabled");
    wr(8'h20, 32'h0);
    rd(8'h0C, 32'h00000100, "R3 full view src40");

    // R8 R9: source 40 urgent
    wr(8'h44, 32'h77777771);
    wr(8'h1C, 32'h00000100);
    outs(1'b1, 1'b1, 1'b1, "R8 both lines");
    check({26'b0, act_id}, 32'd40, "R9 id src40");
    rd(8'h04, 32'h00000100, "R3 urgent view src40");
    rd(8'h0C, 32'h0, "R3 normal view bank1 empty");

    // R9 tie: source 3 also priority 1, lower number wins
    wr(8'h30, 32'h77771777);
    pulse(3);
    wr(8'h18, 32'h00000028);
    #1; check({26'b0, act_id}, 32'd3, "R9 tie lowest number");
    wr(8'h44, 32'h77777770);
    #1; check({26'b0, act_id}, 32'd40, "R9 smaller priority wins");
    check(act_addr, 32'h1A0, "R10 addr src40");

    // R4: clear source 40, zero write has no effect, then clear bank 0
    wr(8'h04, 32'h00000100);
    outs(1'b1, 1'b1, 1'b1, "R4 src3 still urgent");
    check({26'b0, act_id}, 32'd3, "R4 id after clear");
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h00000020, "R4 zero write ignored");
    wr(8'h00, 32'hFFFFFFFF);
    outs(1'b0, 1'b0, 1'b0, "R8 lines drop after clear");
    rd(8'h08, 32'h0, "R4 all ones clears bank");

    // R5: edge and clear on the same clock edge
    @(negedge clk);
    req[7] = 1'b1; we = 1'b1; addr = 8'h08; wdata = 32'h00000080;
    @(negedge clk);
    we = 1'b0;
    rd(8'h08, 32'h00000080, "R5 edge survives clear");
    wr(8'h08, 32'h00000080);
    rd(8'h08, 32'h0, "R2 held level does not re-pend");
    req[7] = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule